// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an input address into an output address by walking a multi-level radix tree held in memory. A request gives the address to translate, the base of the root directory, the bit width of the root level and the total number of translated bits. The walker reads one 64-bit entry per level over a request/response memory port. It checks each entry for validity and leaf status and moves down until it finds a leaf, a missing entry or a bad configuration.

Each directory entry gives the base and the bit width of the level below it. The width of every level is taken away from the remaining translated size, so the size left over when a leaf is reached is the page size. A leaf yields the output address, a three-bit permission set and that page size. Before it answers, the walker sets the leaf's referenced bit on every access and its changed bit on writes. It does this with a compare-and-swap. If another agent has changed the entry in the meantime, the whole walk starts again from the root.

Top module: `radix_walker`

## Requirements
- R1: `reqReady` is high only while the walker is idle. A request is taken on `reqValid && reqReady`, and each accepted request yields exactly one single-cycle `rspValid` pulse.
- R2: Before each level's read, a level width below 5 bits or above the remaining size ends the walk with `rspFault`=1 and `rspCause`=0x00080000, and no read is issued for that level.
- R3: The entry for a level is read at base + 8 × ((address >> (remaining − width)) & (2^width − 1)).
- R4: An entry with bit 63 clear ends the walk with `rspFault`=1 and `rspCause`=0x40000000. On any fault, `rspAddr` and `rspPerm` are zero.
- R5: An entry with bit 63 set and bit 62 clear is a directory. Its bits [55:8] followed by eight zero bits give the next base, and its bits [4:0] give the next level width. The remaining size drops by the current width.
- R6: An entry with bits 63 and 62 set is a leaf. `rspPageSize` is the remaining size after this level. `rspAddr` takes the leaf's page number (bits [55:12] followed by 12 zero bits) above that size and the input address below it.
- R7: `rspPerm` is leaf bits [2:0] (bit 2 read, bit 1 write, bit 0 execute), with the write bit cleared when the final leaf's changed bit (bit 7) is clear.
- R8: If the leaf lacks the referenced bit (bit 8), or the access is a write and the leaf lacks bit 7, a compare-and-swap is issued to the same address. The compare value is the leaf, and the new value is the leaf with bit 8 set and, for writes, bit 7 set. A returned value equal to the compare value means success.
- R9: A compare-and-swap whose returned value differs from the compare value restarts the walk at the root with the original request.
- R10: A directory found at the fourth level ends the walk with the bad-configuration cause 0x00080000.
- R11: At most one memory access is outstanding. A memory request stays asserted, with a stable address and kind, until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and taking a request |
| reqAddr | input | ADDR_W | Address to translate |
| reqWrite | input | 1 | Access is a write |
| reqBase | input | ADDR_W | Root directory base |
| reqLevelSize | input | SIZE_W | Root level width in bits |
| reqTotalSize | input | SIZE_W | Total translated size in bits |
| rspValid | output | 1 | Result valid for one cycle |
| rspFault | output | 1 | Walk ended in a fault |
| rspCause | output | 32 | Fault cause word |
| rspAddr | output | ADDR_W | Translated address |
| rspPerm | output | 3 | Permissions read/write/execute |
| rspPageSize | output | SIZE_W | Page size in bits |
| memReqValid | output | 1 | Memory access request |
| memReqReady | input | 1 | Memory takes the request |
| memReqWrite | output | 1 | Access is a compare-and-swap |
| memReqAddr | output | ADDR_W | Entry address |
| memReqCompare | output | 64 | Compare value for compare-and-swap |
| memReqData | output | 64 | New value for compare-and-swap |
| memRspValid | input | 1 | Memory response present |
| memRspData | input | 64 | Entry read, or old value for compare-and-swap |

## Verification
The assertions take for granted that memory sends exactly one response for each accepted request, and never one while nothing is pending. They also assume that a compare-and-swap response carries the old entry value. The bench memory model keeps to this. It raises ready only when it sees a request, sometimes holds ready low to stall, and answers one cycle after each grant. It models interference from another agent only by changing the stored entry before the compare, so the walker sees a mismatch through the old value that comes back.

// File: rtl/rpw_pkg.sv
package rpw_pkg;
  localparam int ENTRY_W = 64;
  localparam int VALID_BIT = 63;
  localparam int LEAF_BIT = 62;
  localparam int REF_BIT = 8;
  localparam int CHG_BIT = 7;
  localparam int NEXT_BASE_LSB = 8;
  localparam int PAGE_LSB = 12;
  localparam int NEXT_SIZE_W = 5;
  localparam int PERM_W = 3;
  localparam int MIN_LEVEL_BITS = 5;
  localparam logic [2:0] PERM_NO_WRITE = 3'b101;
  localparam logic [31:0] CAUSE_BAD_CFG = 32'h0008_0000;
  localparam logic [31:0] CAUSE_NO_ENTRY = 32'h4000_0000;
  localparam logic [ENTRY_W-1:0] RC_MASK =
    (ENTRY_W'(1) << REF_BIT) | (ENTRY_W'(1) << CHG_BIT);

  typedef struct packed {
    logic loadReq;
    logic restart;
    logic latchEntry;
    logic descend;
    logic commitRc;
    logic resolve;
    logic faultCfg;
    logic faultMiss;
  } walkStrobe_t;

  typedef struct packed {
    logic lvlBad;
    logic entryValid;
    logic entryLeaf;
    logic needRc;
    logic casMatch;
    logic depthLast;
  } walkStatus_t;
endpackage

// File: rtl/rpw_datapath.sv
module rpw_datapath
  import rpw_pkg::*;
#(
  parameter int ADDR_W = 56,
  parameter int SIZE_W = 6,
  parameter int MAX_LEVELS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobe_t        strobe,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqBase,
  input  logic [SIZE_W-1:0]  reqLevelSize,
  input  logic [SIZE_W-1:0]  reqTotalSize,
  input  logic [ENTRY_W-1:0] memRspData,
  output walkStatus_t        status,
  output logic [ADDR_W-1:0]  entryAddr,
  output logic [ENTRY_W-1:0] casCompare,
  output logic [ENTRY_W-1:0] casWrite,
  output logic               rspFault,
  output logic [31:0]        rspCause,
  output logic [ADDR_W-1:0]  rspAddr,
  output logic [PERM_W-1:0]  rspPerm,
  output logic [SIZE_W-1:0]  rspPageSize
);
  localparam int DEPTH_W = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1;

  logic [ADDR_W-1:0]  vaddr, rootBase, curBase;
  logic               isWrite;
  logic [SIZE_W-1:0]  rootLvl, rootTotal, curLvl, remSize;
  logic [DEPTH_W-1:0] depth;
  logic [ENTRY_W-1:0] entry;

  logic [SIZE_W-1:0]  remNext;
  logic [ADDR_W-1:0]  lvlMask, index, pageMask, pageNum, nextBase;
  logic [ENTRY_W-1:0] rcBits;
  logic [PERM_W-1:0]  finalPerm;

  assign remNext   = remSize - curLvl;
  assign lvlMask   = (ADDR_W'(1) << curLvl) - ADDR_W'(1);
  assign index     = (vaddr >> remNext) & lvlMask;
  assign entryAddr = curBase + (index << 3);
  assign pageMask  = (ADDR_W'(1) << remNext) - ADDR_W'(1);
  assign pageNum   = {entry[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
  assign nextBase  = {entry[ADDR_W-1:NEXT_BASE_LSB], {NEXT_BASE_LSB{1'b0}}};
  assign rcBits    = (ENTRY_W'(1) << REF_BIT)
                   | (isWrite ? (ENTRY_W'(1) << CHG_BIT) : '0);
  assign casCompare = entry;
  assign casWrite   = entry | rcBits;
  assign finalPerm  = entry[CHG_BIT] ? entry[PERM_W-1:0]
                                     : (entry[PERM_W-1:0] & PERM_NO_WRITE);

  assign status.lvlBad     = (curLvl < SIZE_W'(MIN_LEVEL_BITS)) || (curLvl > remSize);
  assign status.entryValid = entry[VALID_BIT];
  assign status.entryLeaf  = entry[LEAF_BIT];
  assign status.needRc     = (casWrite != entry);
  assign status.casMatch   = (memRspData == entry);
  assign status.depthLast  = (depth == DEPTH_W'(MAX_LEVELS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaddr <= '0; isWrite <= 1'b0; rootBase <= '0; rootLvl <= '0;
      rootTotal <= '0; curBase <= '0; curLvl <= '0; remSize <= '0;
      depth <= '0; entry <= '0; rspFault <= 1'b0; rspCause <= '0;
      rspAddr <= '0; rspPerm <= '0; rspPageSize <= '0;
    end else begin
      if (strobe.loadReq) begin
        vaddr <= reqAddr; isWrite <= reqWrite;
        rootBase <= reqBase; rootLvl <= reqLevelSize; rootTotal <= reqTotalSize;
        curBase <= reqBase; curLvl <= reqLevelSize; remSize <= reqTotalSize;
        depth <= '0; rspFault <= 1'b0; rspCause <= '0;
        rspAddr <= '0; rspPerm <= '0; rspPageSize <= '0;
      end
      if (strobe.restart) begin
        curBase <= rootBase; curLvl <= rootLvl; remSize <= rootTotal;
        depth <= '0;
      end
      if (strobe.latchEntry) entry <= memRspData;
      if (strobe.commitRc)   entry <= casWrite;
      if (strobe.descend) begin
        curBase <= nextBase;
        curLvl  <= SIZE_W'(entry[NEXT_SIZE_W-1:0]);
        remSize <= remNext;
        depth   <= depth + DEPTH_W'(1);
      end
      if (strobe.resolve) begin
        rspAddr     <= (pageNum & ~pageMask) | (vaddr & pageMask);
        rspPerm     <= finalPerm;
        rspPageSize <= remNext;
      end
      if (strobe.faultCfg) begin
        rspFault <= 1'b1;
        rspCause <= CAUSE_BAD_CFG;
      end
      if (strobe.faultMiss) begin
        rspFault <= 1'b1;
        rspCause <= CAUSE_NO_ENTRY;
      end
    end
  end
endmodule

// File: rtl/rpw_control.sv
module rpw_control
  import rpw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  walkStatus_t status,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        memReqWrite,
  output logic        rspValid,
  output walkStrobe_t strobe
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_READ, ST_WAIT, ST_EVAL,
    ST_SWAP, ST_SWAP_WAIT, ST_FINAL, ST_DONE
  } walkState_t;

  walkState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.loadReq = 1'b1;
        nextState = ST_CHECK;
      end
      ST_CHECK: if (status.lvlBad) begin
        strobe.faultCfg = 1'b1;
        nextState = ST_DONE;
      end else begin
        nextState = ST_READ;
      end
      ST_READ: if (memReqReady) nextState = ST_WAIT;
      ST_WAIT: if (memRspValid) begin
        strobe.latchEntry = 1'b1;
        nextState = ST_EVAL;
      end
      ST_EVAL: begin
        if (!status.entryValid) begin
          strobe.faultMiss = 1'b1;
          nextState = ST_DONE;
        end else if (status.entryLeaf) begin
          if (status.needRc) begin
            nextState = ST_SWAP;
          end else begin
            strobe.resolve = 1'b1;
            nextState = ST_DONE;
          end
        end else if (status.depthLast) begin
          strobe.faultCfg = 1'b1;
          nextState = ST_DONE;
        end else begin
          strobe.descend = 1'b1;
          nextState = ST_CHECK;
        end
      end
      ST_SWAP: if (memReqReady) nextState = ST_SWAP_WAIT;
      ST_SWAP_WAIT: if (memRspValid) begin
        if (status.casMatch) begin
          strobe.commitRc = 1'b1;
          nextState = ST_FINAL;
        end else begin
          strobe.restart = 1'b1;
          nextState = ST_CHECK;
        end
      end
      ST_FINAL: begin
        strobe.resolve = 1'b1;
        nextState = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_READ) || (state == ST_SWAP);
  assign memReqWrite = (state == ST_SWAP);
  assign rspValid    = (state == ST_DONE);
endmodule

// File: rtl/radix_walker.sv
module radix_walker
  import rpw_pkg::*;
#(
  parameter int ADDR_W = 56,
  parameter int SIZE_W = 6,
  parameter int MAX_LEVELS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqBase,
  input  logic [SIZE_W-1:0] reqLevelSize,
  input  logic [SIZE_W-1:0] reqTotalSize,
  output logic              rspValid,
  output logic              rspFault,
  output logic [31:0]       rspCause,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [2:0]        rspPerm,
  output logic [SIZE_W-1:0] rspPageSize,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [63:0]       memReqCompare,
  output logic [63:0]       memReqData,
  input  logic              memRspValid,
  input  logic [63:0]       memRspData
);
  walkStrobe_t strobe;
  walkStatus_t status;

  rpw_control uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .status(status), .reqReady(reqReady),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .rspValid(rspValid), .strobe(strobe)
  );

  rpw_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_LEVELS(MAX_LEVELS)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqBase(reqBase), .reqLevelSize(reqLevelSize),
    .reqTotalSize(reqTotalSize), .memRspData(memRspData), .status(status),
    .entryAddr(memReqAddr), .casCompare(memReqCompare), .casWrite(memReqData),
    .rspFault(rspFault), .rspCause(rspCause), .rspAddr(rspAddr),
    .rspPerm(rspPerm), .rspPageSize(rspPageSize)
  );
endmodule

// File: rtl/rpw_checker.sv
module rpw_checker
  import rpw_pkg::*;
#(
  parameter int ADDR_W = 56
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspFault,
  input logic [31:0]       rspCause,
  input logic [ADDR_W-1:0] rspAddr,
  input logic [2:0]        rspPerm,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [63:0]       memReqCompare,
  input logic [63:0]       memReqData,
  input logic              memRspValid
);
  logic pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          pending <= 1'b0;
    else if (memReqValid && memReqReady) pending <= 1'b1;
    else if (memRspValid)               pending <= 1'b0;
  end

  p_single_access_r11: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> !memReqValid);

  p_response_expected_r11: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> pending);

  p_request_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr) && $stable(memReqWrite));

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_fault_clean_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspAddr == '0 && rspPerm == '0 && $countones(rspCause) == 1);

  p_swap_sets_ref_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqWrite |-> memReqData[REF_BIT]
      && (((memReqData ^ memReqCompare) & ~RC_MASK) == '0)
      && (memReqData != memReqCompare));
endmodule

bind radix_walker rpw_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .rspFault(rspFault), .rspCause(rspCause),
  .rspAddr(rspAddr), .rspPerm(rspPerm), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqWrite(memReqWrite),
  .memReqAddr(memReqAddr), .memReqCompare(memReqCompare),
  .memReqData(memReqData), .memRspValid(memRspValid)
);

// File: tb/tb_radix_walker.sv
`timescale 1ns/1ps
module tb_radix_walker;
  localparam logic [31:0] BAD_CFG  = 32'h0008_0000;
  localparam logic [31:0] NO_ENTRY = 32'h4000_0000;
  localparam logic [55:0] ROOT     = 56'h10000;

  typedef struct packed {
    logic [63:0] va;
    logic        wr;
    logic        inject;
    logic        fault;
    logic [31:0] cause;
    logic [63:0] addr;
    logic [2:0]  perm;
    logic [5:0]  psize;
    logic [7:0]  reads;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{64'h203456, 1'b0, 1'b0, 1'b0, 32'h0,    64'hABCDE456, 3'd7, 6'd12, 8'd2}, // R6
    '{64'h204010, 1'b0, 1'b0, 1'b0, 32'h0,    64'h12345010, 3'd4, 6'd12, 8'd2}, // R7
    '{64'h205000, 1'b0, 1'b0, 1'b1, NO_ENTRY, 64'h0,        3'd0, 6'd0,  8'd2}, // R4
    '{64'h206ABC, 1'b1, 1'b0, 1'b0, 32'h0,    64'h07777ABC, 3'd7, 6'd12, 8'd3}, // R8
    '{64'h207001, 1'b0, 1'b0, 1'b0, 32'h0,    64'h55555001, 3'd1, 6'd12, 8'd3}, // R8
    '{64'h4ABCDE, 1'b0, 1'b0, 1'b0, 32'h0,    64'h400ABCDE, 3'd5, 6'd21, 8'd1}, // R6
    '{64'h600000, 1'b0, 1'b0, 1'b1, BAD_CFG,  64'h0,        3'd0, 6'd0,  8'd1}, // R2
    '{64'h800000, 1'b0, 1'b0, 1'b1, BAD_CFG,  64'h0,        3'd0, 6'd0,  8'd4}, // R10
    '{64'hA3BEEF, 1'b0, 1'b0, 1'b0, 32'h0,    64'h0999BEEF, 3'd2, 6'd16, 8'd2}, // R5
    '{64'h208123, 1'b1, 1'b1, 1'b0, 32'h0,    64'h66666123, 3'd7, 6'd12, 8'd6}  // R9
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic        reqReady;
  logic [55:0] reqAddr = '0, reqBase = '0;
  logic [5:0]  reqLevelSize = '0, reqTotalSize = '0;
  logic        rspValid, rspFault;
  logic [31:0] rspCause;
  logic [55:0] rspAddr;
  logic [2:0]  rspPerm;
  logic [5:0]  rspPageSize;
  logic        memReqValid, memReqWrite;
  logic        memReqReady = 1'b0;
  logic [55:0] memReqAddr;
  logic [63:0] memReqCompare, memReqData;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;

  always #2.5 clk = ~clk;

  radix_walker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqBase(reqBase),
    .reqLevelSize(reqLevelSize), .reqTotalSize(reqTotalSize),
    .rspValid(rspValid), .rspFault(rspFault), .rspCause(rspCause),
    .rspAddr(rspAddr), .rspPerm(rspPerm), .rspPageSize(rspPageSize),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqCompare(memReqCompare), .memReqData(memReqData),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  int checks = 0;
  int failures = 0;
  logic [63:0] mem [longint unsigned];
  int readCount = 0;
  int injectFails = 0;
  logic [55:0] addrLog0, addrLog1;
  logic        sawBusy;

  function automatic logic [63:0] mkDir(input logic [55:0] base, input logic [4:0] lvl);
    return (64'd1 << 63) | {8'd0, base[55:8], 8'd0} | {59'd0, lvl};
  endfunction

  function automatic logic [63:0] mkLeaf(input logic [55:0] rpn, input logic r,
                                         input logic c, input logic [2:0] perm);
    return (64'd3 << 62) | {8'd0, rpn[55:12], 12'd0}
         | ({63'd0, r} << 8) | ({63'd0, c} << 7) | {61'd0, perm};
  endfunction

  function automatic logic [63:0] rdMem(input logic [55:0] a);
    longint unsigned k = longint'(a);
    return mem.exists(k) ? mem[k] : 64'd0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model: grants at a negedge, answers one cycle later
  initial begin
    int stallCnt = 0;
    bit granted = 0;
    logic [55:0] gAddr;
    logic        gWrite;
    logic [63:0] gCmp, gData, old;
    forever begin
      @(negedge clk);
      stallCnt++;
      memRspValid = 1'b0;
      if (granted) begin
        granted = 0;
        memReqReady = 1'b0;
        if (readCount == 0) addrLog0 = gAddr;
        if (readCount == 1) addrLog1 = gAddr;
        readCount++;
        old = rdMem(gAddr);
        if (gWrite) begin
          if (injectFails > 0) begin
            injectFails--;
            old = old | (64'd1 << 8);
            mem[longint'(gAddr)] = old;
          end
          if (old == gCmp) mem[longint'(gAddr)] = gData;
        end
        memRspData  = old;
        memRspValid = 1'b1;
      end else if (memReqValid && (stallCnt % 3 != 1)) begin
        memReqReady = 1'b1;
        granted = 1;
        gAddr = memReqAddr; gWrite = memReqWrite;
        gCmp = memReqCompare; gData = memReqData;
      end else begin
        memReqReady = 1'b0;
      end
    end
  end

  task automatic runWalk(input logic [63:0] va, input logic wr, input logic [55:0] base,
                         input logic [5:0] lvl, input logic [5:0] total);
    int waitCnt = 0;
    @(negedge clk);
    readCount = 0; addrLog0 = '0; addrLog1 = '0;
    reqValid = 1'b1; reqAddr = va[55:0]; reqWrite = wr;
    reqBase = base; reqLevelSize = lvl; reqTotalSize = total;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    sawBusy = !reqReady;
    while (!rspValid && waitCnt < 3000) begin
      @(negedge clk);
      waitCnt++;
    end
    check(rspValid, "R1", "response pulse", {63'd0, rspValid}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    // tree: root 9 bits at 0x10000, 30 bits total
    mem[64'h10008] = mkDir(56'h20000, 5'd9);
    mem[64'h10010] = mkLeaf(56'h40000000, 1'b1, 1'b1, 3'd5);
    mem[64'h10018] = mkDir(56'h21000, 5'd3);
    mem[64'h10020] = mkDir(56'h30000, 5'd5);
    mem[64'h10028] = mkDir(56'h34000, 5'd5);
    mem[64'h20018] = mkLeaf(56'hABCDE000, 1'b1, 1'b1, 3'd7);
    mem[64'h20020] = mkLeaf(56'h12345000, 1'b1, 1'b0, 3'd6);
    mem[64'h20030] = mkLeaf(56'h07777000, 1'b0, 1'b0, 3'd7);
    mem[64'h20038] = mkLeaf(56'h55555000, 1'b0, 1'b0, 3'd3);
    mem[64'h20040] = mkLeaf(56'h66666000, 1'b0, 1'b0, 3'd7);
    mem[64'h30000] = mkDir(56'h31000, 5'd5);
    mem[64'h31000] = mkDir(56'h32000, 5'd5);
    mem[64'h32000] = mkDir(56'h33000, 5'd5);
    mem[64'h34018] = mkLeaf(56'h09990000, 1'b1, 1'b1, 3'd2);

    repeat (3) @(negedge clk);
    // R1: reset state
    check(reqReady == 1'b1, "R1", "reset reqReady", {63'd0, reqReady}, 64'd1);
    check(rspValid == 1'b0, "R1", "reset rspValid", {63'd0, rspValid}, 64'd0);
    check(memReqValid == 1'b0, "R11", "reset memReqValid", {63'd0, memReqValid}, 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      injectFails = VECS[i].inject ? 1 : 0;
      runWalk(VECS[i].va, VECS[i].wr, ROOT, 6'd9, 6'd30);
      check(rspFault == VECS[i].fault, "R4", $sformatf("vec%0d fault", i),
            {63'd0, rspFault}, {63'd0, VECS[i].fault});
      check(rspCause == VECS[i].cause, "R2", $sformatf("vec%0d cause", i),
            {32'd0, rspCause}, {32'd0, VECS[i].cause});
      check({8'd0, rspAddr} == VECS[i].addr, "R6", $sformatf("vec%0d addr", i),
            {8'd0, rspAddr}, VECS[i].addr);
      check(rspPerm == VECS[i].perm, "R7", $sformatf("vec%0d perm", i),
            {61'd0, rspPerm}, {61'd0, VECS[i].perm});
      check(rspPageSize == VECS[i].psize, "R5", $sformatf("vec%0d page size", i),
            {58'd0, rspPageSize}, {58'd0, VECS[i].psize});
      check(readCount == int'(VECS[i].reads), "R9", $sformatf("vec%0d accesses", i),
            64'(readCount), {56'd0, VECS[i].reads});
    end

    // R1: walker busy right after accepting
    check(sawBusy, "R1", "reqReady low while busy", {63'd0, !sawBusy}, 64'd0);

    // R8: write-back results visible in memory
    check(rdMem(56'h20030) == mkLeaf(56'h07777000, 1'b1, 1'b1, 3'd7), "R8",
          "write sets ref and change", rdMem(56'h20030), mkLeaf(56'h07777000, 1'b1, 1'b1, 3'd7));
    check(rdMem(56'h20038) == mkLeaf(56'h55555000, 1'b1, 1'b0, 3'd3), "R8",
          "read sets ref only", rdMem(56'h20038), mkLeaf(56'h55555000, 1'b1, 1'b0, 3'd3));
    check(rdMem(56'h20040) == mkLeaf(56'h66666000, 1'b1, 1'b1, 3'd7), "R9",
          "retried swap landed", rdMem(56'h20040), mkLeaf(56'h66666000, 1'b1, 1'b1, 3'd7));

    // R3: entry addresses of a two-level walk
    runWalk(64'h203456, 1'b0, ROOT, 6'd9, 6'd30);
    check(addrLog0 == 56'h10008, "R3", "root entry address", {8'd0, addrLog0}, 64'h10008);
    check(addrLog1 == 56'h20018, "R3", "leaf entry address", {8'd0, addrLog1}, 64'h20018);
    check(readCount == 2, "R8", "no swap when bits set", 64'(readCount), 64'd2);

    // R3: level-two address with a five-bit level
    runWalk(64'hA3BEEF, 1'b0, ROOT, 6'd9, 6'd30);
    check(addrLog1 == 56'h34018, "R3", "narrow level address", {8'd0, addrLog1}, 64'h34018);

    // R2: root width below 5 bits, no read
    runWalk(64'h203456, 1'b0, ROOT, 6'd4, 6'd30);
    check(rspFault && rspCause == BAD_CFG, "R2", "narrow root cause",
          {32'd0, rspCause}, {32'd0, BAD_CFG});
    check(readCount == 0, "R2", "narrow root reads", 64'(readCount), 64'd0);

    // R2: root width above total size, no read
    runWalk(64'h203456, 1'b0, ROOT, 6'd9, 6'd8);
    check(rspFault && rspCause == BAD_CFG, "R2", "oversized root cause",
          {32'd0, rspCause}, {32'd0, BAD_CFG});
    check(readCount == 0, "R2", "oversized root reads", 64'(readCount), 64'd0);

    // R10: the depth-limit case again with a write request
    runWalk(64'h800000, 1'b1, ROOT, 6'd9, 6'd30);
    check(rspCause == BAD_CFG && readCount == 4, "R10", "depth limit",
          {32'd0, rspCause}, {32'd0, BAD_CFG});

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule